// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a shared memory that two processors reach through separate ports, and lets those processors signal each other. It keeps two message words, one per port, and one interrupt flag per port. A port sends a message by writing the other port's mailbox. That write stores the word and raises the receiver's interrupt. The receiver reads its own mailbox to fetch the message, and that read clears its interrupt. The word is stored and returned bit for bit, with no meaning given to its content.

Each side has a synchronous memory-style interface: an active-high select, an active-high write enable, an address, write data and registered read data. Each side also has an active-low registered interrupt output and an active-high busy input. Busy comes from an arbiter outside this block. While a side's busy is high, a write from that side still stores the word but raises no interrupt, and a read by that side of its own mailbox returns the word but leaves its interrupt set. The left mailbox is at the all-ones address and the right mailbox is one below it. Other addresses touch nothing here, and a read of one returns zero.

Top module: `mbx_dualport_irq`

## Requirements
- R1: After a cycle with `rst` high, both `*_irq_n` outputs are 1, both `*_rdata` are 0 and both mailboxes hold 0.
- R2: A write by the right port to the all-ones address, with `rt_busy` low, drives `lt_irq_n` to 0 from the next cycle. A write by the left port to all-ones minus one, with `lt_busy` low, does the same for `rt_irq_n`.
- R3: A read by a port of its own mailbox (left: all-ones, right: all-ones minus one), with its busy low, drives its `*_irq_n` to 1 from the next cycle.
- R4: A read by a port of the other port's mailbox returns that word and leaves the other port's interrupt unchanged.
- R5: While a port's busy is high, its write to the other port's mailbox does not change the other port's interrupt.
- R6: While a port's busy is high, its read of its own mailbox does not clear its own interrupt.
- R7: A read (`cs`=1, `we`=0) presents the addressed mailbox word on `*_rdata` one cycle later, exactly as it was written. Between reads, `*_rdata` holds its value.
- R8: If a flag is set and cleared in the same cycle, the set wins and the interrupt is 0 afterwards.
- R9: If both ports write the same mailbox in one cycle, the left port's word is stored.
- R10: An access to any address other than the two mailbox addresses changes no mailbox and no interrupt, and a read of such an address returns 0.
- R11: A port writing its own mailbox stores the word but does not change either interrupt.
- R12: A read in the same cycle as a write to the same mailbox returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lt_cs | input | 1 | Left port select |
| lt_we | input | 1 | Left port write enable |
| lt_addr | input | ADDR_W | Left port address |
| lt_wdata | input | DATA_W | Left port write data |
| lt_rdata | output | DATA_W | Left port read data, registered |
| lt_busy | input | 1 | Left port busy from the external arbiter |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_cs | input | 1 | Right port select |
| rt_we | input | 1 | Right port write enable |
| rt_addr | input | ADDR_W | Right port address |
| rt_wdata | input | DATA_W | Right port write data |
| rt_rdata | output | DATA_W | Right port read data, registered |
| rt_busy | input | 1 | Right port busy from the external arbiter |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The case that matters is a sender setting a flag in the same cycle that the receiver clears it, by reading its own mailbox. A second case is both ports writing one mailbox in the same cycle. The bench drives these collisions as directed steps, with and without busy on either side. Its random phase aims most accesses at the two mailbox addresses, so that sets, clears, busy-masked events and same-cycle read/write pairs collide often. A bench model applies the stated priorities: set over clear, left over right on data, and old data on a colliding read. Every cycle, the model's interrupts and read words are compared against the ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_LT   = 0;
    localparam int SIDE_RT   = 1;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      hit_own;
        logic      hit_peer;
    } side_dec_t;

    function automatic int peer_of(input int side);
        return (side == SIDE_LT) ? SIDE_RT : SIDE_LT;
    endfunction

    function automatic logic is_rd(input side_dec_t d);
        return d.kind == ACC_READ;
    endfunction

    function automatic logic is_wr(input side_dec_t d);
        return d.kind == ACC_WRITE;
    endfunction

endpackage

// File: rtl/mbx_side_decode.sv
module mbx_side_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SIDE   = 0
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output side_dec_t         dec
);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] OWN_ADDR  = (SIDE == SIDE_LT) ? TOP_ADDR : NEXT_ADDR;
    localparam logic [ADDR_W-1:0] PEER_ADDR = (SIDE == SIDE_LT) ? NEXT_ADDR : TOP_ADDR;

    always_comb begin
        dec = '0;
        if (cs) dec.kind = we ? ACC_WRITE : ACC_READ;
        else    dec.kind = ACC_IDLE;
        dec.hit_own  = cs && (addr == OWN_ADDR);
        dec.hit_peer = cs && (addr == PEER_ADDR);
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  side_dec_t [NUM_SIDES-1:0]  dec,
    input  logic [NUM_SIDES-1:0][DATA_W-1:0] wdata,
    output logic [NUM_SIDES-1:0][DATA_W-1:0] box
);
    for (genvar b = 0; b < NUM_SIDES; b++) begin : g_box
        localparam int PEER = (b == SIDE_LT) ? SIDE_RT : SIDE_LT;
        logic              wr_by_owner;
        logic              wr_by_peer;
        logic              wr_lt_wins;
        logic [DATA_W-1:0] nxt;

        always_comb begin
            wr_by_owner = is_wr(dec[b]) && dec[b].hit_own;
            wr_by_peer  = is_wr(dec[PEER]) && dec[PEER].hit_peer;
            // left side has priority on the data when both write one box
            wr_lt_wins  = (b == SIDE_LT) ? wr_by_owner : wr_by_peer;
            nxt         = box[b];
            if (wr_by_owner || wr_by_peer) begin
                if (wr_lt_wins) nxt = wdata[SIDE_LT];
                else            nxt = wdata[SIDE_RT];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) box[b] <= '0;
            else     box[b] <= nxt;
        end
    end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (set_req) pending <= 1'b1;
        else if (clr_req) pending <= 1'b0;
    end

    assign irq_n = ~pending;
endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  side_dec_t         dec,
    input  logic [DATA_W-1:0] own_box,
    input  logic [DATA_W-1:0] peer_box,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        if (dec.hit_own)       sel = own_box;
        else if (dec.hit_peer) sel = peer_box;
        else                   sel = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)              rdata <= '0;
        else if (is_rd(dec))  rdata <= sel;
    end
endmodule

// File: rtl/mbx_dualport_irq.sv
module mbx_dualport_irq
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lt_cs,
    input  logic              lt_we,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    input  logic              lt_busy,
    output logic              lt_irq_n,
    input  logic              rt_cs,
    input  logic              rt_we,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    input  logic              rt_busy,
    output logic              rt_irq_n
);
    logic      [NUM_SIDES-1:0]             cs_v, we_v, busy_v, irq_v;
    logic      [NUM_SIDES-1:0][ADDR_W-1:0] addr_v;
    logic      [NUM_SIDES-1:0][DATA_W-1:0] wdata_v, rdata_v, box_v;
    side_dec_t [NUM_SIDES-1:0]             dec_v;

    assign cs_v    = {rt_cs, lt_cs};
    assign we_v    = {rt_we, lt_we};
    assign busy_v  = {rt_busy, lt_busy};
    assign addr_v  = {rt_addr, lt_addr};
    assign wdata_v = {rt_wdata, lt_wdata};

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int PEER = (s == SIDE_LT) ? SIDE_RT : SIDE_LT;
        logic set_req, clr_req;

        mbx_side_decode #(.ADDR_W(ADDR_W), .SIDE(s)) dec_i (
            .cs(cs_v[s]), .we(we_v[s]), .addr(addr_v[s]), .dec(dec_v[s])
        );

        // the peer writing this side's box raises it, unless the peer is busy
        assign set_req = is_wr(dec_v[PEER]) && dec_v[PEER].hit_peer && !busy_v[PEER];
        // this side reading its own box drops it, unless this side is busy
        assign clr_req = is_rd(dec_v[s]) && dec_v[s].hit_own && !busy_v[s];

        mbx_irq_flag flag_i (
            .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req), .irq_n(irq_v[s])
        );

        mbx_read_port #(.DATA_W(DATA_W)) rd_i (
            .clk(clk), .rst(rst), .dec(dec_v[s]),
            .own_box(box_v[s]), .peer_box(box_v[PEER]), .rdata(rdata_v[s])
        );
    end

    mbx_store #(.DATA_W(DATA_W)) store_i (
        .clk(clk), .rst(rst), .dec(dec_v), .wdata(wdata_v), .box(box_v)
    );

    assign lt_rdata = rdata_v[SIDE_LT];
    assign rt_rdata = rdata_v[SIDE_RT];
    assign lt_irq_n = irq_v[SIDE_LT];
    assign rt_irq_n = irq_v[SIDE_RT];
endmodule

// File: rtl/mbx_dualport_irq_chk.sv
module mbx_dualport_irq_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              lt_cs,
    input logic              lt_we,
    input logic [ADDR_W-1:0] lt_addr,
    input logic [DATA_W-1:0] lt_rdata,
    input logic              lt_busy,
    input logic              lt_irq_n,
    input logic              rt_cs,
    input logic              rt_we,
    input logic [ADDR_W-1:0] rt_addr,
    input logic [DATA_W-1:0] rt_rdata,
    input logic              rt_busy,
    input logic              rt_irq_n
);
    localparam logic [ADDR_W-1:0] A_LT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] A_RT = A_LT - 1'b1;

    logic lt_set, lt_clr_raw, rt_set, rt_clr_raw;
    assign lt_set     = rt_cs && rt_we && rt_addr == A_LT && !rt_busy;
    assign lt_clr_raw = lt_cs && !lt_we && lt_addr == A_LT;
    assign rt_set     = lt_cs && lt_we && lt_addr == A_RT && !lt_busy;
    assign rt_clr_raw = rt_cs && !rt_we && rt_addr == A_RT;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lt_irq_n && rt_irq_n && lt_rdata == '0 && rt_rdata == '0));

    assert_set_lt_R2: assert property (@(posedge clk) disable iff (rst)
        lt_set |=> !lt_irq_n);
    assert_set_rt_R2: assert property (@(posedge clk) disable iff (rst)
        rt_set |=> !rt_irq_n);

    assert_clear_lt_R3: assert property (@(posedge clk) disable iff (rst)
        (lt_clr_raw && !lt_busy && !lt_set) |=> lt_irq_n);

    assert_peer_read_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (lt_cs && !lt_we && lt_addr == A_RT && !rt_clr_raw) |=> $stable(rt_irq_n));

    assert_busy_no_set_R5: assert property (@(posedge clk) disable iff (rst)
        (lt_cs && lt_we && lt_addr == A_RT && lt_busy && !rt_clr_raw) |=> $stable(rt_irq_n));

    assert_busy_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rt_clr_raw && rt_busy && !rt_set) |=> $stable(rt_irq_n));

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rt_set && rt_clr_raw && !rt_busy) |=> !rt_irq_n);
endmodule

bind mbx_dualport_irq mbx_dualport_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst),
    .lt_cs(lt_cs), .lt_we(lt_we), .lt_addr(lt_addr), .lt_rdata(lt_rdata),
    .lt_busy(lt_busy), .lt_irq_n(lt_irq_n),
    .rt_cs(rt_cs), .rt_we(rt_we), .rt_addr(rt_addr), .rt_rdata(rt_rdata),
    .rt_busy(rt_busy), .rt_irq_n(rt_irq_n)
);

// File: tb/mbx_dualport_irq_tb_top.sv
module mbx_dualport_irq_tb_top;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [AW-1:0] A_LT = {AW{1'b1}};
    localparam logic [AW-1:0] A_RT = A_LT - 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lt_cs = 0, lt_we = 0, lt_busy = 0, rt_cs = 0, rt_we = 0, rt_busy = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic [DW-1:0] lt_wdata = '0, rt_wdata = '0;
    logic [DW-1:0] lt_rdata, rt_rdata;
    logic lt_irq_n, rt_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [DW-1:0] m_box [2];
    logic          m_pend [2];
    logic [DW-1:0] m_rd [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_dualport_irq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .lt_cs(lt_cs), .lt_we(lt_we), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
        .lt_rdata(lt_rdata), .lt_busy(lt_busy), .lt_irq_n(lt_irq_n),
        .rt_cs(rt_cs), .rt_we(rt_we), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
        .rt_rdata(rt_rdata), .rt_busy(rt_busy), .rt_irq_n(rt_irq_n)
    );

    function automatic logic [DW-1:0] read_val(input logic [AW-1:0] a);
        if (a == A_LT)      return m_box[0];
        else if (a == A_RT) return m_box[1];
        else                return '0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic set_l, clr_l, set_r, clr_r;
        logic [DW-1:0] nb0, nb1;
        if (rst) begin
            m_box[0] = '0; m_box[1] = '0; m_pend[0] = 0; m_pend[1] = 0;
            m_rd[0] = '0; m_rd[1] = '0;
            return;
        end
        set_l = rt_cs && rt_we && rt_addr == A_LT && !rt_busy;
        clr_l = lt_cs && !lt_we && lt_addr == A_LT && !lt_busy;
        set_r = lt_cs && lt_we && lt_addr == A_RT && !lt_busy;
        clr_r = rt_cs && !rt_we && rt_addr == A_RT && !rt_busy;
        if (lt_cs && !lt_we) m_rd[0] = read_val(lt_addr);
        if (rt_cs && !rt_we) m_rd[1] = read_val(rt_addr);
        nb0 = m_box[0]; nb1 = m_box[1];
        if (lt_cs && lt_we && lt_addr == A_LT)      nb0 = lt_wdata;
        else if (rt_cs && rt_we && rt_addr == A_LT) nb0 = rt_wdata;
        if (lt_cs && lt_we && lt_addr == A_RT)      nb1 = lt_wdata;
        else if (rt_cs && rt_we && rt_addr == A_RT) nb1 = rt_wdata;
        m_box[0] = nb0; m_box[1] = nb1;
        m_pend[0] = set_l ? 1'b1 : (clr_l ? 1'b0 : m_pend[0]);
        m_pend[1] = set_r ? 1'b1 : (clr_r ? 1'b0 : m_pend[1]);
    endtask

    task automatic cyc(input logic lc, input logic lw, input logic [AW-1:0] la,
                       input logic [DW-1:0] ld, input logic lb,
                       input logic rc, input logic rw, input logic [AW-1:0] ra,
                       input logic [DW-1:0] rd, input logic rb, input string req);
        @(negedge clk);
        lt_cs = lc; lt_we = lw; lt_addr = la; lt_wdata = ld; lt_busy = lb;
        rt_cs = rc; rt_we = rw; rt_addr = ra; rt_wdata = rd; rt_busy = rb;
        @(posedge clk);
        model_step();
        #1;
        check(req, "lt_irq_n", {{(DW-1){1'b0}}, lt_irq_n}, {{(DW-1){1'b0}}, ~m_pend[0]});
        check(req, "rt_irq_n", {{(DW-1){1'b0}}, rt_irq_n}, {{(DW-1){1'b0}}, ~m_pend[1]});
        check(req, "lt_rdata", lt_rdata, m_rd[0]);
        check(req, "rt_rdata", rt_rdata, m_rd[1]);
    endtask

    task automatic idle(input string req);
        cyc(0, 0, '0, '0, 0, 0, 0, '0, '0, 0, req);
    endtask

    task automatic rd_both(input string req);
        cyc(1, 0, A_LT, '0, 0, 1, 0, A_RT, '0, 0, req);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1;
        idle("R1"); idle("R1");
        rst = 1'b0;
        idle("R1");
        // R1: check reset values at ports directly
        check("R1", "reset lt_irq_n", {{(DW-1){1'b0}}, lt_irq_n}, {{(DW-1){1'b0}}, 1'b1});
        check("R1", "reset rt_rdata", rt_rdata, '0);

        // R2: right sends to left, left sends to right
        cyc(0, 0, '0, '0, 0, 1, 1, A_LT, 16'hA5C3, 0, "R2");
        check("R2", "lt irq set", {{(DW-1){1'b0}}, lt_irq_n}, '0);
        cyc(1, 1, A_RT, 16'h0F1E, 0, 0, 0, '0, '0, 0, "R2");
        // R4: peer reads of each box leave flags alone
        cyc(1, 0, A_RT, '0, 0, 1, 0, A_LT, '0, 0, "R4");
        check("R4", "rt irq still set", {{(DW-1){1'b0}}, rt_irq_n}, '0);
        check("R7", "peer box word", lt_rdata, 16'h0F1E);
        // R6: busy blocks own-read clear
        cyc(1, 0, A_LT, '0, 1, 0, 0, '0, '0, 0, "R6");
        check("R6", "lt irq kept", {{(DW-1){1'b0}}, lt_irq_n}, '0);
        check("R7", "own box word", lt_rdata, 16'hA5C3);
        // R3: owner reads clear
        rd_both("R3");
        check("R3", "lt irq cleared", {{(DW-1){1'b0}}, lt_irq_n}, {{(DW-1){1'b0}}, 1'b1});
        // R5: busy sender raises nothing but still stores
        cyc(1, 1, A_RT, 16'h7777, 1, 0, 0, '0, '0, 0, "R5");
        check("R5", "rt irq untouched", {{(DW-1){1'b0}}, rt_irq_n}, {{(DW-1){1'b0}}, 1'b1});
        cyc(0, 0, '0, '0, 0, 1, 0, A_RT, '0, 0, "R5");
        // R8: set and clear on the right flag in the same cycle
        cyc(1, 1, A_RT, 16'h1111, 0, 1, 0, A_RT, '0, 0, "R8");
        check("R8", "set wins", {{(DW-1){1'b0}}, rt_irq_n}, '0);
        // R12: that read returned the word before the write
        check("R12", "old word", rt_rdata, 16'h7777);
        rd_both("R3");
        // R9: both write the left box
        cyc(1, 1, A_LT, 16'hBEEF, 0, 1, 1, A_LT, 16'hDEAD, 0, "R9");
        cyc(0, 0, '0, '0, 0, 1, 0, A_LT, '0, 0, "R9");
        check("R9", "left data kept", rt_rdata, 16'hBEEF);
        // R11: own-box write raises nothing
        check("R11", "lt irq after own write", {{(DW-1){1'b0}}, lt_irq_n}, '0);
        rd_both("R3");
        cyc(0, 0, '0, '0, 0, 1, 1, A_RT, 16'h2222, 0, "R11");
        check("R11", "rt irq after own write", {{(DW-1){1'b0}}, rt_irq_n}, {{(DW-1){1'b0}}, 1'b1});
        // R10: other addresses
        cyc(1, 1, 12'h123, 16'h3333, 0, 1, 1, 12'hFFD, 16'h4444, 0, "R10");
        cyc(1, 0, 12'h123, '0, 0, 1, 0, A_RT, '0, 0, "R10");
        check("R10", "plain addr reads zero", lt_rdata, '0);
        check("R10", "box untouched", rt_rdata, 16'h2222);

        // random phase, aimed at the mailbox addresses
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] la, ra;
            int unsigned pl, pr;
            pl = $urandom_range(0, 9); pr = $urandom_range(0, 9);
            la = (pl < 4) ? A_LT : (pl < 8) ? A_RT : AW'($urandom);
            ra = (pr < 4) ? A_LT : (pr < 8) ? A_RT : AW'($urandom);
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom), la, DW'($urandom),
                1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) != 0), 1'($urandom), ra, DW'($urandom),
                1'($urandom_range(0, 3) == 0), "R7");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run hung actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule